// File: doc/BRIEF.md
# Vector Byte Window Extractor

This block executes one vector operation: it takes a window of bytes that lies across two source vectors. The caller presents a 32-bit instruction word and two 128-bit operands with a one-cycle `in_valid` strobe. If the word is an extract, the block joins the two operands, with the first operand in the low bytes and the second above it. It then returns the bytes that begin at a 4-bit immediate start index. In full-width mode the window is 16 bytes wide. In half-width mode it covers only the low 8 bytes of each operand, and the upper half of the result is zero.

Another operation uses the same major opcode. Bit 10 of the instruction separates the two, and the block does not claim words of that other operation. Any encoding that is not an extract produces no output flag. A half-width extract whose index reaches past the 8-byte range raises an illegal flag instead of a result. Results and flags appear one clock after the sampled strobe.

Top module: `vec_extract_unit`

## Requirements
- R1: A word is an extract only when bit 31 is 0, bits 29:21 equal 9'b1_0111_0000, bit 15 is 0 and bit 10 is 0. A legal extract sampled with `in_valid` raises `out_valid` for exactly the following cycle.
- R2: In full mode (bit 30 = 1), with index k = bits 14:11, result byte j is `op_a` byte k+j when k+j <= 15, and otherwise `op_b` byte k+j-16. Byte j occupies bits 8j+7:8j.
- R3: In half mode (bit 30 = 0), result byte j for j < 8 is `op_a` byte k+j when k+j <= 7, and otherwise `op_b` byte k+j-8. Result bits 127:64 are zero.
- R4: A half-mode extract with index bit 3 set (bit 14 = 1) raises `out_illegal` for one cycle. In that cycle `out_valid` is low, and `result` keeps its previous value.
- R5: A word that matches the extract pattern except that bit 10 = 1 (the element-move operation) raises neither flag and leaves `result` unchanged.
- R6: Other words, such as one with bit 15 = 1 or with different bits 29:21, raise neither flag and leave `result` unchanged.
- R7: Index 0 returns `op_a` unchanged in full mode. In half mode it returns the low 64 bits of `op_a` with zero above.
- R8: A cycle without `in_valid` gives low flags in the next cycle and leaves `result` unchanged.
- R9: A synchronous active-high `rst` clears `result`, `out_valid` and `out_illegal` at the next clock edge.
- R10: The register-number fields (bits 20:16, 9:5 and 4:0) have no effect on `result` or on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the inputs as sampled this cycle |
| instr | input | 32 | Instruction word |
| op_a | input | 128 | First operand, supplies the low part of the window |
| op_b | input | 128 | Second operand, supplies the upper part of the window |
| result | output | 128 | Registered byte window |
| out_valid | output | 1 | A result was written in the previous cycle |
| out_illegal | output | 1 | The previous sampled word was an extract with a bad index |

## Verification
A wrong lane select or a wrong width mask shows in `result` exactly one cycle after the strobe. It appears as a byte taken from the wrong operand or at the wrong offset. The operand bytes are distinct tags, so each wrong byte names its source. A decode fault, such as claiming the element-move word or missing the bit-15 check, shows the same cycle as a spurious flag or a changed `result` where the previous value should hold. Hold behaviour is therefore compared against the last legal result after every rejected or idle strobe.

// File: rtl/vext_pkg.sv
package vext_pkg;
  localparam int IDX_BITS = 4;
  localparam logic [8:0] EXT_MAJOR = 9'b1_0111_0000;

  typedef struct packed {
    logic                load;
    logic                markIllegal;
    logic                halfWidth;
    logic [IDX_BITS-1:0] startIdx;
  } ctrlStrobes_t;
endpackage

// File: rtl/vext_ctrl.sv
module vext_ctrl
  import vext_pkg::*;
(
  input  logic         inValid,
  input  logic [31:0]  instr,
  output ctrlStrobes_t strobes
);
  logic majorHit;
  logic isExtract;
  logic halfMode;
  logic badIdx;
  logic unusedRegFields;

  // Register-number fields do not take part in decode
  assign unusedRegFields = ^{instr[20:16], instr[9:0]};

  always_comb begin
    majorHit  = !instr[31] && (instr[29:21] == EXT_MAJOR);
    isExtract = majorHit && !instr[15] && !instr[10];
    halfMode  = !instr[30];
    badIdx    = halfMode && instr[14];

    strobes.load        = inValid && isExtract && !badIdx;
    strobes.markIllegal = inValid && isExtract && badIdx;
    strobes.halfWidth   = halfMode;
    strobes.startIdx    = instr[14:11];
  end
endmodule

// File: rtl/vext_datapath.sv
module vext_datapath
  import vext_pkg::*;
#(
  parameter int VEC_BYTES = 16,
  parameter int BYTE_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  ctrlStrobes_t                strobes,
  input  logic [VEC_BYTES*BYTE_W-1:0] opA,
  input  logic [VEC_BYTES*BYTE_W-1:0] opB,
  output logic [VEC_BYTES*BYTE_W-1:0] result,
  output logic                        outValid,
  output logic                        outIllegal
);
  localparam int VEC_W      = VEC_BYTES * BYTE_W;
  localparam int HALF_BYTES = VEC_BYTES / 2;
  localparam int IDX_W      = $clog2(VEC_BYTES);
  localparam int HIDX_W     = IDX_W - 1;

  logic [BYTE_W-1:0] aBytes [VEC_BYTES];
  logic [BYTE_W-1:0] bBytes [VEC_BYTES];
  logic [VEC_W-1:0]  nextResult;

  for (genvar s = 0; s < VEC_BYTES; s++) begin : g_split
    assign aBytes[s] = opA[s*BYTE_W +: BYTE_W];
    assign bBytes[s] = opB[s*BYTE_W +: BYTE_W];
  end

  // One mux per result lane. In full mode the lane reads position idx+j of the
  // 2N-byte pair; in half mode it reads position idx+j of the N-byte pair.
  for (genvar j = 0; j < VEC_BYTES; j++) begin : g_lane
    localparam logic [IDX_W:0] OFF = j[IDX_W:0];
    logic [IDX_W:0]    pos;
    logic [BYTE_W-1:0] fullByte;
    logic [BYTE_W-1:0] halfByte;

    assign pos = {1'b0, strobes.startIdx[IDX_W-1:0]} + OFF;

    always_comb begin
      fullByte = pos[IDX_W] ? bBytes[pos[IDX_W-1:0]] : aBytes[pos[IDX_W-1:0]];
    end

    if (j < HALF_BYTES) begin : g_low
      logic [IDX_W-1:0] hIdx;
      assign hIdx = {{(IDX_W-HIDX_W){1'b0}}, pos[HIDX_W-1:0]};
      always_comb begin
        halfByte = pos[HIDX_W] ? bBytes[hIdx] : aBytes[hIdx];
      end
    end else begin : g_high
      assign halfByte = '0;
    end

    assign nextResult[j*BYTE_W +: BYTE_W] = strobes.halfWidth ? halfByte : fullByte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result     <= '0;
      outValid   <= 1'b0;
      outIllegal <= 1'b0;
    end else begin
      outValid   <= strobes.load;
      outIllegal <= strobes.markIllegal;
      if (strobes.load) begin
        result <= nextResult;
      end
    end
  end
endmodule

// File: rtl/vec_extract_unit.sv
module vec_extract_unit
  import vext_pkg::*;
#(
  parameter int VEC_BYTES = 16,
  parameter int BYTE_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [31:0]                 instr,
  input  logic [VEC_BYTES*BYTE_W-1:0] op_a,
  input  logic [VEC_BYTES*BYTE_W-1:0] op_b,
  output logic [VEC_BYTES*BYTE_W-1:0] result,
  output logic                        out_valid,
  output logic                        out_illegal
);
  ctrlStrobes_t strobes;

  vext_ctrl i_ctrl (
    .inValid (in_valid),
    .instr   (instr),
    .strobes (strobes)
  );

  vext_datapath #(
    .VEC_BYTES (VEC_BYTES),
    .BYTE_W    (BYTE_W)
  ) i_dp (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .opA        (op_a),
    .opB        (op_b),
    .result     (result),
    .outValid   (out_valid),
    .outIllegal (out_illegal)
  );
endmodule

// File: rtl/vext_chk.sv
module vext_chk #(
  parameter int VEC_BYTES = 16,
  parameter int BYTE_W    = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        in_valid,
  input logic [31:0]                 instr,
  input logic [VEC_BYTES*BYTE_W-1:0] result,
  input logic                        out_valid,
  input logic                        out_illegal
);
  localparam int VEC_W = VEC_BYTES * BYTE_W;

  // R4
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_valid && out_illegal));

  // R4
  illegal_holds_chk: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> $stable(result));

  // R1
  valid_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_illegal && $stable(result)));

  // R5
  elem_move_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[10]) |=> (!out_valid && !out_illegal && $stable(result)));

  // R3
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(instr[30])) |-> (result[VEC_W-1:VEC_W/2] == '0));

  // R9
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (result == '0 && !out_valid && !out_illegal));
endmodule

bind vec_extract_unit vext_chk #(
  .VEC_BYTES (VEC_BYTES),
  .BYTE_W    (BYTE_W)
) i_vext_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .instr       (instr),
  .result      (result),
  .out_valid   (out_valid),
  .out_illegal (out_illegal)
);

// File: tb/test_vec_extract_unit.sv
module test_vec_extract_unit;
  typedef struct packed {
    logic [1:0]  kind;   // 0 extract, 1 element move, 2 bit15 set, 3 other major
    logic        full;
    logic [3:0]  idx;
    logic [14:0] regs;   // bits 20:16, 9:5, 4:0
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t TABLE [NVEC] = '{
    '{2'd0, 1'b1, 4'd0,  15'h0000},  // R7 full idx 0
    '{2'd0, 1'b1, 4'd1,  15'h0421},  // R2
    '{2'd0, 1'b1, 4'd5,  15'h0000},  // R2
    '{2'd0, 1'b1, 4'd5,  15'h7FFF},  // R10 same idx, other regs
    '{2'd0, 1'b1, 4'd8,  15'h1234},  // R2
    '{2'd0, 1'b1, 4'd15, 15'h0000},  // R2 top index
    '{2'd1, 1'b1, 4'd4,  15'h0000},  // R5 element move
    '{2'd0, 1'b0, 4'd0,  15'h0000},  // R7 half idx 0
    '{2'd0, 1'b0, 4'd3,  15'h2A55},  // R3
    '{2'd0, 1'b0, 4'd7,  15'h0000},  // R3 top half index
    '{2'd0, 1'b0, 4'd8,  15'h0000},  // R4 illegal
    '{2'd0, 1'b0, 4'd15, 15'h0000},  // R4 illegal
    '{2'd2, 1'b1, 4'd2,  15'h0000},  // R6 bit15 set
    '{2'd3, 1'b1, 4'd2,  15'h0000},  // R6 other major
    '{2'd1, 1'b0, 4'd1,  15'h0000},  // R5 half element move
    '{2'd0, 1'b1, 4'd12, 15'h5A5A},  // R2
    '{2'd0, 1'b0, 4'd2,  15'h7FFF},  // R3 / R10
    '{2'd0, 1'b1, 4'd9,  15'h0000}   // R2
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] opA = '0;
  logic [127:0] opB = '0;
  logic [127:0] result;
  logic         outValid;
  logic         outIllegal;

  int checks = 0;
  int fails  = 0;
  logic [127:0] lastRes = '0;

  always #10 clk = ~clk;

  vec_extract_unit i_vec_extract_unit (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (inValid),
    .instr       (instr),
    .op_a        (opA),
    .op_b        (opB),
    .result      (result),
    .out_valid   (outValid),
    .out_illegal (outIllegal)
  );

  function automatic logic [31:0] buildInstr(vec_t v);
    logic [31:0] w;
    w = '0;
    w[29:21] = (v.kind == 2'd3) ? 9'b1_0111_0001 : 9'b1_0111_0000;
    w[30]    = v.full;
    w[15]    = (v.kind == 2'd2);
    w[10]    = (v.kind == 2'd1);
    w[14:11] = v.idx;
    w[20:16] = v.regs[14:10];
    w[9:5]   = v.regs[9:5];
    w[4:0]   = v.regs[4:0];
    return w;
  endfunction

  function automatic logic [127:0] model(logic full, logic [3:0] k,
                                         logic [127:0] a, logic [127:0] b);
    logic [127:0] r;
    r = '0;
    for (int j = 0; j < 16; j++) begin
      int p;
      p = int'(k) + j;
      if (full) begin
        r[j*8 +: 8] = (p < 16) ? a[p*8 +: 8] : b[(p-16)*8 +: 8];
      end else if (j < 8) begin
        r[j*8 +: 8] = (p < 8) ? a[p*8 +: 8] : b[(p-8)*8 +: 8];
      end
    end
    return r;
  endfunction

  task automatic checkVec(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic applyOne(logic [31:0] w, logic [127:0] a, logic [127:0] b, logic v);
    @(negedge clk);
    instr = w; opA = a; opB = b; inValid = v;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [127:0] tagA;
    logic [127:0] tagB;
    for (int i = 0; i < 16; i++) begin
      tagA[i*8 +: 8] = 8'hA0 + 8'(i);
      tagB[i*8 +: 8] = 8'hB0 + 8'(i);
    end

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    checkVec("R9 reset result", result, '0);
    checkVec("R9 reset flags", {126'b0, outValid, outIllegal}, '0);

    for (int n = 0; n < NVEC; n++) begin
      vec_t v;
      logic isExt, bad, expV, expI;
      string tag;
      v = TABLE[n];
      isExt = (v.kind == 2'd0);
      bad   = !v.full && v.idx[3];
      expV  = isExt && !bad;
      expI  = isExt && bad;
      applyOne(buildInstr(v), tagA, tagB, 1'b1);
      if (expV) lastRes = model(v.full, v.idx, tagA, tagB);
      tag = !isExt ? (v.kind == 2'd1 ? "R5" : "R6") :
            bad ? "R4" : (v.idx == 0 ? "R7" : (v.full ? "R2" : "R3"));
      checkVec($sformatf("%s/R1 vec %0d result", tag, n), result, lastRes);
      checkVec($sformatf("%s/R1 vec %0d flags", tag, n),
               {126'b0, outValid, outIllegal}, {126'b0, expV, expI});
    end

    // R10 same window with other register fields and other operands
    begin
      logic [127:0] a2 = 128'h0F1E2D3C4B5A69788796A5B4C3D2E1F0;
      logic [127:0] b2 = 128'h123456789ABCDEF00FEDCBA987654321;
      applyOne(buildInstr('{2'd0, 1'b1, 4'd11, 15'h0000}), a2, b2, 1'b1);
      lastRes = model(1'b1, 4'd11, a2, b2);
      checkVec("R2 second pattern", result, lastRes);
      applyOne(buildInstr('{2'd0, 1'b1, 4'd11, 15'h6B3D}), a2, b2, 1'b1);
      checkVec("R10 regs ignored", result, lastRes);
    end

    // R8 legal word presented without strobe
    applyOne(buildInstr('{2'd0, 1'b1, 4'd3, 15'h0}), tagB, tagA, 1'b0);
    checkVec("R8 idle result", result, lastRes);
    checkVec("R8 idle flags", {126'b0, outValid, outIllegal}, '0);

    // R9 reset after a valid result
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    checkVec("R9 mid reset result", result, '0);
    checkVec("R9 mid reset flags", {126'b0, outValid, outIllegal}, '0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule